// File: doc/BRIEF.md
# Data Trace Sync Controller and Packer

This block turns bus access events into variable-length data trace messages. Each accepted event carries a read/write flag, an address, a size code, a source tag and a data value. One cycle later the block presents a packed message word together with its bit length. It also flags whether the message is a synchronising one.

A synchronising message carries the complete address. A normal message carries only the bits that changed since the address of the previous message, so it is usually much shorter. Several conditions can force synchronisation:

- leaving reset
- trace being switched on
- leaving debug halt
- a queue overrun
- a rising edge on the external event input, when that feature is enabled
- a previous message dropped because it touched secure memory
- a run of 255 normal messages in a row

Each condition is latched until a synchronising message is actually emitted. Queueing and serial output of the messages are handled downstream.

Top module: `dtrace_sync_packer`

## Requirements
- R1: While `rst_n` is low, `msg_valid`, `msg_sync` and `msg_len` are zero. The first message after reset is synchronising.
- R2: An event presented while `trace_en` is low produces no message. The first message after `trace_en` rises is synchronising.
- R3: The first message after `debug_mode` falls is synchronising.
- R4: A pulse on `ovf_pulse` while `trace_en` is high makes the next message synchronising. This includes an event in the same cycle as the pulse.
- R5: After 255 consecutive normal messages, the 256th is synchronising. This holds even with no other trigger.
- R6: A rising edge on `evt_in` makes the next message synchronising only when `evt_sync_en` is high. When `evt_sync_en` is low, the edge has no effect.
- R7: A pulse on `secure_drop` makes the next message synchronising.
- R8: Every trigger is held across idle cycles until a synchronising message is emitted. Emitting that message clears all held triggers and restarts the 255-message count, so the following message is normal.
- R9: Fields are packed from bit 0 upward: 6-bit code, 4-bit source, 3-bit size, address field, data field. The codes are:
  - normal read `000110`
  - normal write `000101`
  - synchronising read `001110`
  - synchronising write `001101`

  All bits at and above `msg_len` are zero.
- R10: A synchronising message uses the full 32-bit address. A normal message uses the XOR of the address with the previous message's address, trimmed to its highest set bit, with a minimum of 1 bit.
- R11: The size code selects how much data is kept:
  - `000`: 64-bit doubleword, sent as one value
  - `001`: 8 bits
  - `010`: 16 bits
  - any other code: 32 bits

  The masked value is trimmed to its highest set bit, with a minimum of 1 bit.
- R12: A message appears exactly one cycle after its accepted event. `msg_len` equals 13 plus the address and data field widths, and lies between 15 and 109.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Data trace enable |
| debug_mode | input | 1 | High while the core is halted in debug |
| ovf_pulse | input | 1 | Queue overrun indication, one cycle |
| evt_in | input | 1 | External event input |
| evt_sync_en | input | 1 | Allows `evt_in` edges to force synchronisation |
| secure_drop | input | 1 | Previous message was lost to a secure access |
| ev_valid | input | 1 | Bus access event present |
| ev_write | input | 1 | 1 = write, 0 = read |
| ev_addr | input | 32 | Access address |
| ev_size | input | 3 | Access size code |
| ev_src | input | 4 | Source tag |
| ev_data | input | 64 | Access data |
| msg_valid | output | 1 | Message word valid this cycle |
| msg_sync | output | 1 | Message is synchronising |
| msg_bits | output | 109 | Packed message, LSB first |
| msg_len | output | 7 | Number of meaningful bits in `msg_bits` |

## Verification
Any faulty held trigger or period count shows up on the very next accepted event. That message's sync flag, code, and length (since a full address is 32 bits wide) all disagree with expectation. A stale previous-address register instead corrupts the relative address field and the length of the next normal message. The periodic count only becomes visible on the 256th message after a synchronising one, so it is driven through a full run.

// File: rtl/dts_pkg.sv
package dts_pkg;
   localparam logic [5:0] TC_RD_NORM = 6'b000110;
   localparam logic [5:0] TC_WR_NORM = 6'b000101;
   localparam logic [5:0] TC_RD_SYNC = 6'b001110;
   localparam logic [5:0] TC_WR_SYNC = 6'b001101;

   localparam logic [2:0] SZ_DWORD = 3'b000;
   localparam logic [2:0] SZ_BYTE  = 3'b001;
   localparam logic [2:0] SZ_HALF  = 3'b010;

   // index of each held trigger
   typedef enum int unsigned {
      TRG_RESET  = 0,
      TRG_ENABLE = 1,
      TRG_DEBUG  = 2,
      TRG_OVF    = 3,
      TRG_EVT    = 4,
      TRG_SECURE = 5
   } trig_idx_e;

   localparam int NUM_TRIG = 6;
endpackage

// File: rtl/dts_sigbits.sv
module dts_sigbits #(
   parameter int W   = 32,
   localparam int NW = $clog2(W + 1)
) (
   input  logic [W-1:0]  val,
   output logic [NW-1:0] nbits
);
   generate
      if (W < 1) begin : g_bad
         $error("dts_sigbits: W must be at least 1");
      end
   endgenerate

   always_comb begin
      nbits = NW'(1);
      for (int i = 0; i < W; i++) begin
         if (val[i]) nbits = NW'(i + 1);
      end
   end
endmodule

// File: rtl/dts_trigger.sv
module dts_trigger
   import dts_pkg::*;
#(
   parameter int PERIOD = 255,
   localparam int CW    = $clog2(PERIOD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trace_en,
   input  logic debug_mode,
   input  logic ovf_pulse,
   input  logic evt_in,
   input  logic evt_sync_en,
   input  logic secure_drop,
   input  logic fire,
   output logic need_sync
);
   generate
      if (PERIOD < 1) begin : g_bad
         $error("dts_trigger: PERIOD must be at least 1");
      end
   endgenerate

   logic [NUM_TRIG-1:0] held_q, arrive;
   logic                en_q, dbg_q, evt_q;
   logic [CW-1:0]       run_q;
   logic                period_hit;

   always_comb begin
      arrive             = '0;
      arrive[TRG_ENABLE] = trace_en & ~en_q;
      arrive[TRG_DEBUG]  = dbg_q & ~debug_mode;
      arrive[TRG_OVF]    = ovf_pulse & trace_en;
      arrive[TRG_EVT]    = evt_in & ~evt_q & evt_sync_en;
      arrive[TRG_SECURE] = secure_drop;
   end

   assign period_hit = (run_q == CW'(PERIOD));
   assign need_sync  = (|held_q) | (|arrive) | period_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q          <= '0;
         held_q[TRG_RESET] <= 1'b1;
         en_q            <= 1'b0;
         dbg_q           <= 1'b0;
         evt_q           <= 1'b0;
         run_q           <= '0;
      end else begin
         en_q  <= trace_en;
         dbg_q <= debug_mode;
         evt_q <= evt_in;
         if (fire && need_sync) begin
            held_q <= '0;
            run_q  <= '0;
         end else begin
            held_q <= held_q | arrive;
            if (fire) run_q <= run_q + CW'(1);
         end
      end
   end

   // R5
   period_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && run_q == CW'(PERIOD)) |-> need_sync);

   // R8
   run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && need_sync) |=> (run_q == '0));
endmodule

// File: rtl/dts_packer.sv
module dts_packer
   import dts_pkg::*;
#(
   parameter int  ADDR_W  = 32,
   parameter int  DATA_W  = 64,
   parameter int  SRC_W   = 4,
   parameter int  SIZE_W  = 3,
   parameter int  TC_W    = 6,
   parameter bit  REL_ADDR = 1'b1,
   localparam int HDR_W   = TC_W + SRC_W + SIZE_W,
   localparam int MSG_W   = HDR_W + ADDR_W + DATA_W,
   localparam int LEN_W   = $clog2(MSG_W + 1),
   localparam int AN_W    = $clog2(ADDR_W + 1),
   localparam int DN_W    = $clog2(DATA_W + 1)
) (
   input  logic              ev_write,
   input  logic              sync,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [ADDR_W-1:0] prev_addr,
   input  logic [SIZE_W-1:0] ev_size,
   input  logic [SRC_W-1:0]  ev_src,
   input  logic [DATA_W-1:0] ev_data,
   output logic [MSG_W-1:0]  bits,
   output logic [LEN_W-1:0]  len
);
   generate
      if (TC_W != 6 || SIZE_W != 3) begin : g_bad_hdr
         $error("dts_packer: code must be 6 bits and size 3 bits");
      end
      if (DATA_W < 32) begin : g_bad_data
         $error("dts_packer: DATA_W must be at least 32");
      end
   endgenerate

   logic [ADDR_W-1:0] a_short, a_field;
   logic [AN_W-1:0]   a_short_n, a_n;
   logic [DATA_W-1:0] d_mask, d_field;
   logic [DN_W-1:0]   d_n;
   logic [TC_W-1:0]   tcode;

   generate
      if (REL_ADDR) begin : g_rel
         assign a_short = ev_addr ^ prev_addr;
      end else begin : g_abs
         assign a_short = ev_addr;
      end
   endgenerate

   dts_sigbits #(.W(ADDR_W)) u_asig (.val(a_short), .nbits(a_short_n));
   dts_sigbits #(.W(DATA_W)) u_dsig (.val(d_field), .nbits(d_n));

   always_comb begin
      int keep;
      case (ev_size)
         SZ_DWORD: keep = DATA_W;
         SZ_BYTE:  keep = 8;
         SZ_HALF:  keep = 16;
         default:  keep = 32;
      endcase
      if (keep >= DATA_W) d_mask = '1;
      else                d_mask = (DATA_W'(1) << keep) - DATA_W'(1);
   end

   assign d_field = ev_data & d_mask;
   assign a_field = sync ? ev_addr : a_short;
   assign a_n     = sync ? AN_W'(ADDR_W) : a_short_n;

   always_comb begin
      case ({sync, ev_write})
         2'b00:   tcode = TC_RD_NORM;
         2'b01:   tcode = TC_WR_NORM;
         2'b10:   tcode = TC_RD_SYNC;
         default: tcode = TC_WR_SYNC;
      endcase
   end

   always_comb begin
      bits = MSG_W'(tcode)
           | (MSG_W'(ev_src)  << TC_W)
           | (MSG_W'(ev_size) << (TC_W + SRC_W))
           | (MSG_W'(a_field) << HDR_W)
           | (MSG_W'(d_field) << (LEN_W'(HDR_W) + LEN_W'(a_n)));
      len  = LEN_W'(HDR_W) + LEN_W'(a_n) + LEN_W'(d_n);
   end
endmodule

// File: rtl/dtrace_sync_packer.sv
module dtrace_sync_packer
   import dts_pkg::*;
#(
   parameter int  ADDR_W   = 32,
   parameter int  DATA_W   = 64,
   parameter int  SRC_W    = 4,
   parameter int  SIZE_W   = 3,
   parameter int  PERIOD   = 255,
   parameter bit  REL_ADDR = 1'b1,
   localparam int TC_W     = 6,
   localparam int HDR_W    = TC_W + SRC_W + SIZE_W,
   localparam int MSG_W    = HDR_W + ADDR_W + DATA_W,
   localparam int LEN_W    = $clog2(MSG_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trace_en,
   input  logic              debug_mode,
   input  logic              ovf_pulse,
   input  logic              evt_in,
   input  logic              evt_sync_en,
   input  logic              secure_drop,
   input  logic              ev_valid,
   input  logic              ev_write,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [SIZE_W-1:0] ev_size,
   input  logic [SRC_W-1:0]  ev_src,
   input  logic [DATA_W-1:0] ev_data,
   output logic              msg_valid,
   output logic              msg_sync,
   output logic [MSG_W-1:0]  msg_bits,
   output logic [LEN_W-1:0]  msg_len
);
   logic              fire, need_sync;
   logic [ADDR_W-1:0] prev_addr_q;
   logic [MSG_W-1:0]  pk_bits;
   logic [LEN_W-1:0]  pk_len;

   assign fire = ev_valid & trace_en;

   dts_trigger #(.PERIOD(PERIOD)) u_trig (
      .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .debug_mode(debug_mode),
      .ovf_pulse(ovf_pulse), .evt_in(evt_in), .evt_sync_en(evt_sync_en),
      .secure_drop(secure_drop), .fire(fire), .need_sync(need_sync)
   );

   dts_packer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .SIZE_W(SIZE_W),
      .TC_W(TC_W), .REL_ADDR(REL_ADDR)
   ) u_pack (
      .ev_write(ev_write), .sync(need_sync), .ev_addr(ev_addr),
      .prev_addr(prev_addr_q), .ev_size(ev_size), .ev_src(ev_src),
      .ev_data(ev_data), .bits(pk_bits), .len(pk_len)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid   <= 1'b0;
         msg_sync    <= 1'b0;
         msg_bits    <= '0;
         msg_len     <= '0;
         prev_addr_q <= '0;
      end else begin
         msg_valid <= fire;
         if (fire) begin
            msg_sync    <= need_sync;
            msg_bits    <= pk_bits;
            msg_len     <= pk_len;
            prev_addr_q <= ev_addr;
         end
      end
   end

   // R12
   len_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_len >= LEN_W'(HDR_W + 2) && msg_len <= LEN_W'(MSG_W)));

   // R12
   one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $past(fire));

   // R9
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> ((msg_bits >> msg_len) == '0));

   // R9
   tcode_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_bits[3] == msg_sync));

   // R10
   sync_full_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_sync) |-> (msg_len >= LEN_W'(HDR_W + ADDR_W + 1)));
endmodule

// File: tb/dtrace_sync_packer_test.sv
module dtrace_sync_packer_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         trace_en = 1'b0, debug_mode = 1'b0, ovf_pulse = 1'b0;
   logic         evt_in = 1'b0, evt_sync_en = 1'b0, secure_drop = 1'b0;
   logic         ev_valid = 1'b0, ev_write = 1'b0;
   logic [31:0]  ev_addr = '0;
   logic [2:0]   ev_size = '0;
   logic [3:0]   ev_src = '0;
   logic [63:0]  ev_data = '0;
   logic         msg_valid, msg_sync;
   logic [108:0] msg_bits;
   logic [6:0]   msg_len;

   int n_run = 0, n_fail = 0;
   logic [31:0] m_prev = '0;

   always #2 clk = ~clk;

   dtrace_sync_packer uut (
      .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .debug_mode(debug_mode),
      .ovf_pulse(ovf_pulse), .evt_in(evt_in), .evt_sync_en(evt_sync_en),
      .secure_drop(secure_drop), .ev_valid(ev_valid), .ev_write(ev_write),
      .ev_addr(ev_addr), .ev_size(ev_size), .ev_src(ev_src), .ev_data(ev_data),
      .msg_valid(msg_valid), .msg_sync(msg_sync), .msg_bits(msg_bits),
      .msg_len(msg_len)
   );

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [2:0]  size;
      logic [3:0]  src;
      logic [63:0] data;
      logic        sync;
      logic [6:0]  len;
   } vec_t;

   localparam vec_t VECS [0:4] = '{
      '{1'b0, 32'h0000_1000, 3'd3, 4'd2,  64'h0000_0000_0000_00FF, 1'b1, 7'd53},
      '{1'b0, 32'h0000_1004, 3'd3, 4'd5,  64'h0000_0000_0000_0001, 1'b0, 7'd17},
      '{1'b1, 32'h0000_1004, 3'd1, 4'd9,  64'h0000_0000_0000_01FF, 1'b0, 7'd22},
      '{1'b1, 32'h8000_0000, 3'd0, 4'd15, 64'h8000_0000_0000_0001, 1'b0, 7'd109},
      '{1'b0, 32'h8000_0000, 3'd2, 4'd0,  64'h0000_0000_0000_0000, 1'b0, 7'd15}
   };

   function automatic int sig(input logic [63:0] v, input int w);
      int n = 1;
      for (int i = 0; i < w; i++) if (v[i]) n = i + 1;
      return n;
   endfunction

   function automatic logic [108:0] model(input logic wr, input logic sy,
         input logic [31:0] a, input logic [31:0] pa, input logic [2:0] sz,
         input logic [3:0] s, input logic [63:0] d, output int len);
      logic [108:0] m = '0;
      logic [5:0]   tc;
      logic [31:0]  av;
      logic [63:0]  dv;
      int al, dl, keep, p;
      tc = sy ? (wr ? 6'b001101 : 6'b001110) : (wr ? 6'b000101 : 6'b000110);
      av = sy ? a : (a ^ pa);
      al = sy ? 32 : sig({32'd0, av}, 32);
      keep = (sz == 3'b000) ? 64 : (sz == 3'b001) ? 8 : (sz == 3'b010) ? 16 : 32;
      dv = '0;
      for (int i = 0; i < keep; i++) dv[i] = d[i];
      dl = sig(dv, 64);
      p = 0;
      for (int i = 0; i < 6; i++)  begin m[p] = tc[i]; p++; end
      for (int i = 0; i < 4; i++)  begin m[p] = s[i];  p++; end
      for (int i = 0; i < 3; i++)  begin m[p] = sz[i]; p++; end
      for (int i = 0; i < al; i++) begin m[p] = av[i]; p++; end
      for (int i = 0; i < dl; i++) begin m[p] = dv[i]; p++; end
      len = p;
      return m;
   endfunction

   task automatic check(input string tag, input logic ok, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // drive one event starting at a negedge, sample at the following negedge
   task automatic send(input string tag, input logic wr, input logic [31:0] a,
         input logic [2:0] sz, input logic [3:0] s, input logic [63:0] d,
         input logic exp_msg, input logic exp_sync);
      logic [108:0] eb;
      int el;
      ev_valid = 1'b1; ev_write = wr; ev_addr = a; ev_size = sz;
      ev_src = s; ev_data = d;
      eb = model(wr, exp_sync, a, m_prev, sz, s, d, el);
      @(negedge clk);
      ev_valid = 1'b0;
      check(tag, msg_valid == exp_msg, "valid", 128'(msg_valid), 128'(exp_msg));
      if (exp_msg) begin
         check(tag, msg_sync == exp_sync, "sync", 128'(msg_sync), 128'(exp_sync));
         check(tag, msg_len == 7'(el), "len", 128'(msg_len), 128'(el));
         check(tag, msg_bits == eb, "bits", 128'(msg_bits), 128'(eb));
         m_prev = a;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", msg_valid == 1'b0 && msg_sync == 1'b0 && msg_len == '0,
            "reset outputs", 128'({msg_valid, msg_sync, msg_len}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1 first sync, then R9 R10 R11 R12 packing cases
      trace_en = 1'b1;
      for (int i = 0; i < 5; i++) begin
         send("R10/R11", VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].src,
              VECS[i].data, 1'b1, VECS[i].sync);
         check("R12", msg_len == VECS[i].len, "table len",
               128'(msg_len), 128'(VECS[i].len));
      end

      // R3 leave debug, with idle gap (R8 sticky)
      @(negedge clk); debug_mode = 1'b1;
      @(negedge clk); @(negedge clk); debug_mode = 1'b0;
      repeat (3) @(negedge clk);
      send("R3", 1'b0, 32'h2000_0040, 3'd3, 4'd1, 64'h1234, 1'b1, 1'b1);
      send("R8", 1'b0, 32'h2000_0044, 3'd3, 4'd1, 64'h55, 1'b1, 1'b0);

      // R4 overrun in same cycle as event
      ovf_pulse = 1'b1;
      send("R4", 1'b1, 32'h2000_0048, 3'd2, 4'd3, 64'hBEEF, 1'b1, 1'b1);
      ovf_pulse = 1'b0;
      send("R8", 1'b1, 32'h2000_004C, 3'd2, 4'd3, 64'h1, 1'b1, 1'b0);

      // R6 event edge ignored when not enabled
      evt_sync_en = 1'b0; evt_in = 1'b1;
      @(negedge clk); evt_in = 1'b0;
      send("R6", 1'b0, 32'h2000_0050, 3'd1, 4'd4, 64'h7, 1'b1, 1'b0);
      // R6 enabled
      evt_sync_en = 1'b1; evt_in = 1'b1;
      @(negedge clk); evt_in = 1'b0;
      send("R6", 1'b0, 32'h2000_0054, 3'd1, 4'd4, 64'h8, 1'b1, 1'b1);
      evt_sync_en = 1'b0;

      // R7 secure drop
      secure_drop = 1'b1;
      @(negedge clk); secure_drop = 1'b0;
      @(negedge clk);
      send("R7", 1'b1, 32'h3000_0000, 3'd0, 4'd6, 64'hFFFF_0000_0000_0000, 1'b1, 1'b1);

      // R2 disabled trace drops events, re-enable forces sync
      trace_en = 1'b0;
      send("R2", 1'b0, 32'h3000_0010, 3'd3, 4'd2, 64'h9, 1'b0, 1'b0);
      trace_en = 1'b1;
      @(negedge clk);
      send("R2", 1'b0, 32'h3000_0014, 3'd3, 4'd2, 64'hA, 1'b1, 1'b1);

      // R5 periodic: 255 normal messages, then a sync one
      for (int k = 0; k < 255; k++)
         send("R5", k[0], 32'h4000_0000 + 32'(k * 4), 3'd3, 4'd7, 64'(k), 1'b1, 1'b0);
      send("R5", 1'b0, 32'h4000_1000, 3'd3, 4'd7, 64'h3, 1'b1, 1'b1);
      send("R8", 1'b0, 32'h4000_1004, 3'd3, 4'd7, 64'h3, 1'b1, 1'b0);

      // R1 reset again: held reset trigger forces sync
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", msg_valid == 1'b0, "valid in reset", 128'(msg_valid), 128'(0));
      rst_n = 1'b1;
      m_prev = '0;
      @(negedge clk);
      send("R1", 1'b1, 32'h0000_0008, 3'd1, 4'd1, 64'h80, 1'b1, 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule